// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

An eight-input interrupt controller that turns a set of request lines into a single interrupt to the processor and tracks which levels the processor is currently servicing. A rising request line is captured in a request register and stays there while the line is held high. A mask register filters captured requests. An in-service register records the levels under service and sets a blocking level, so that only strictly more urgent requests can nest on top of a running handler. Input 0 is the most urgent and input 7 the least.

When the processor strobes `ack`, the controller picks the most urgent eligible request. It clears that request, marks its level as in service and, one cycle later, presents an 8-bit vector made of a programmable 5-bit base and the 3-bit level. Software ends a handler with a non-specific end-of-interrupt strobe, which retires the most urgent in-service level. Three mode inputs change how blocking is worked out. Automatic end-of-interrupt never records service. Special fully nested mode lets a downstream controller, cascaded into input `CASC`, raise further requests while its own level is in service. Special mask mode turns blocking over to the mask register alone.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A request whose mask bit is 1 (bit i of `mask_data`, written on `mask_wr`, masks input i) never raises `int_out` and never wins an acknowledge; clearing the bit lets the held request through.
- R2: A request is captured on a 0-to-1 change of its input line and stays pending only while the line stays high; a line held high after its request was acknowledged does not request again.
- R3: On `ack` the eligible request with the lowest input number wins; the cycle after, `vec_valid` is 1 and `vector` equals `{vec_base, level}` with the level in bits 2:0.
- R4: In normal mode a set in-service bit holds off requests at its own and all higher-numbered inputs, while requests at lower-numbered inputs still raise `int_out` and nest, each acknowledge adding its level to `isr_q`.
- R5: An `eoi` strobe clears only the lowest-numbered bit set in `isr_q`, which releases requests held off by that level alone.
- R6: `int_out` is 1 whenever an eligible request exists, and it is 0 in any cycle where `ack` is 1.
- R7: With `auto_eoi` at 1, an acknowledge returns the vector but leaves `isr_q` unchanged, so less urgent requests are not held off.
- R8: With `sfnm` at 1, a new request on input `CASC` (default 2) is eligible while its own in-service bit is set; inputs numbered above `CASC` stay held off by that bit.
- R9: With `smm` at 1, in-service bits hold off nothing; only the mask register decides eligibility.
- R10: An acknowledge with no eligible request returns `{vec_base, 3'd7}` and changes no in-service bit.
- R11: After reset, `int_out`, `vec_valid`, `vector`, `isr_q` and the mask are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Request lines, bit 0 most urgent |
| mask_wr | input | 1 | Load the mask register from `mask_data` |
| mask_data | input | 8 | New mask, 1 masks the input |
| vec_base | input | 5 | Upper five bits of every vector |
| ack | input | 1 | One-cycle acknowledge strobe |
| eoi | input | 1 | One-cycle non-specific end-of-interrupt |
| auto_eoi | input | 1 | Automatic end-of-interrupt mode |
| sfnm | input | 1 | Special fully nested mode for the cascade input |
| smm | input | 1 | Special mask mode |
| int_out | output | 1 | Interrupt to the processor |
| vec_valid | output | 1 | Vector valid, one cycle after `ack` |
| vector | output | 8 | Returned vector |
| isr_q | output | 8 | Levels currently in service |

## Verification
A corrupted in-service register shows at once on `int_out`: a stale bit holds a pending request off, so the interrupt stays low when it should rise, and a lost bit lets an equal or less urgent request raise it again in the next cycle. A wrong request register shows at the next acknowledge, where the level field of `vector` differs from the most urgent eligible input, or a spurious code 7 appears where a real level should. The end-of-interrupt order shows within one cycle on `isr_q`, and again on `int_out` when the wrong level is released.

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int CASC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       mask_wr,
  input  logic [7:0] mask_data,
  input  logic [4:0] vec_base,
  input  logic       ack,
  input  logic       eoi,
  input  logic       auto_eoi,
  input  logic       sfnm,
  input  logic       smm,
  output logic       int_out,
  output logic       vec_valid,
  output logic [7:0] vector,
  output logic [7:0] isr_q
);
  logic [7:0] irq_d, irr, imr, isr;
  logic [7:0] pend, allow, elig, win, eoi_bit;
  logic [2:0] win_lvl;
  logic       any;

  assign pend = irr & ~imr;

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      logic [7:0] le, lt;
      le = 8'((9'd2 << i) - 9'd1);
      lt = 8'((9'd1 << i) - 9'd1);
      if (smm)                  allow[i] = 1'b1;
      else if (sfnm && i == CASC) allow[i] = ~|(isr & lt);
      else                      allow[i] = ~|(isr & le);
    end
  end

  assign elig    = pend & allow;
  assign any     = |elig;
  assign int_out = any & ~ack;

  always_comb begin
    win     = '0;
    win_lvl = 3'd7;
    eoi_bit = '0;
    for (int i = 7; i >= 0; i--) begin
      if (elig[i]) begin
        win     = '0;
        win[i]  = 1'b1;
        win_lvl = 3'(i);
      end
      if (isr[i]) begin
        eoi_bit    = '0;
        eoi_bit[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_d     <= '0;
      irr       <= '0;
      imr       <= '0;
      isr       <= '0;
      vec_valid <= 1'b0;
      vector    <= '0;
    end else begin
      irq_d     <= irq_in;
      irr       <= irq_in & (irr | ~irq_d) & ~(ack ? win : 8'h00);
      if (mask_wr) imr <= mask_data;
      isr       <= (isr & ~(eoi ? eoi_bit : 8'h00)) | ((ack && !auto_eoi) ? win : 8'h00);
      vec_valid <= ack;
      if (ack) vector <= {vec_base, any ? win_lvl : 3'd7};
    end
  end

  assign isr_q = isr;

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr & ~imr) != 8'h00); // R1

  AST_NEST_ADDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && any && !eoi && !auto_eoi && !smm && !sfnm)
      |=> $countones(isr) == $countones($past(isr)) + 1); // R4

  AST_EOI_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && isr != 8'h00)
      |=> $countones(isr) + 1 == $countones($past(isr))); // R5

  AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && auto_eoi && !eoi) |=> isr == $past(isr)); // R7

  AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !any && !eoi) |=> vector[2:0] == 3'd7 && isr == $past(isr)); // R10

  AST_VALID_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid); // R3
endmodule

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
  logic       clk = 0, rst_n = 0;
  logic [7:0] irq_in = 0, mask_data = 0;
  logic       mask_wr = 0, ack = 0, eoi = 0, auto_eoi = 0, sfnm = 0, smm = 0;
  logic [4:0] vec_base = 5'h09;
  logic       int_out, vec_valid;
  logic [7:0] vector, isr_q;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  nest_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_wr(mask_wr),
    .mask_data(mask_data), .vec_base(vec_base), .ack(ack), .eoi(eoi),
    .auto_eoi(auto_eoi), .sfnm(sfnm), .smm(smm), .int_out(int_out),
    .vec_valid(vec_valid), .vector(vector), .isr_q(isr_q));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic do_ack(input string req, input logic [2:0] lvl, input logic [7:0] isr_exp);
    ack = 1; #1;
    chk("R6 int low during ack", {7'd0, int_out}, 8'd0);
    step(); ack = 0;
    chk("R3 vec_valid", {7'd0, vec_valid}, 8'd1);
    chk(req, vector, {vec_base, lvl});
    chk(req, isr_q, isr_exp);
  endtask

  task automatic do_eoi(input string req, input logic [7:0] isr_exp);
    eoi = 1; step(); eoi = 0;
    chk(req, isr_q, isr_exp);
  endtask

  task automatic set_mask(input logic [7:0] m);
    mask_data = m; mask_wr = 1; step(); mask_wr = 0;
  endtask

  task automatic t_reset();
    chk("R11 int", {7'd0, int_out}, 8'd0);
    chk("R11 valid", {7'd0, vec_valid}, 8'd0);
    chk("R11 vector", vector, 8'd0);
    chk("R11 isr", isr_q, 8'd0);
    irq_in = 8'h80; step();
    chk("R11 mask clear", {7'd0, int_out}, 8'd1);
    irq_in = 0; step(); step();
  endtask

  task automatic t_priority();
    irq_in = 8'h28; step();
    chk("R6 int high", {7'd0, int_out}, 8'd1);
    do_ack("R3 lowest wins", 3'd3, 8'h08);
    chk("R4 lower held", {7'd0, int_out}, 8'd0);
    irq_in = 8'h2A; step();
    chk("R4 higher nests", {7'd0, int_out}, 8'd1);
    do_ack("R4 nest vector", 3'd1, 8'h0A);
    do_eoi("R5 clears level 1", 8'h08);
    chk("R5 level 5 still held", {7'd0, int_out}, 8'd0);
    do_eoi("R5 clears level 3", 8'h00);
    chk("R5 level 5 released", {7'd0, int_out}, 8'd1);
    do_ack("R3 level 5", 3'd5, 8'h20);
    do_eoi("R5 last", 8'h00);
    chk("R2 held line no retrigger", {7'd0, int_out}, 8'd0);
    irq_in = 0; step();
  endtask

  task automatic t_mask();
    set_mask(8'h10);
    irq_in = 8'h10; step();
    chk("R1 masked silent", {7'd0, int_out}, 8'd0);
    set_mask(8'h00);
    chk("R1 unmasked", {7'd0, int_out}, 8'd1);
    do_ack("R1 vector", 3'd4, 8'h10);
    do_eoi("R1 eoi", 8'h00);
    irq_in = 0; step();
  endtask

  task automatic t_spurious();
    irq_in = 8'h40; step();
    chk("R2 captured", {7'd0, int_out}, 8'd1);
    irq_in = 0; step();
    chk("R2 dropped", {7'd0, int_out}, 8'd0);
    do_ack("R10 spurious", 3'd7, 8'h00);
  endtask

  task automatic t_aeoi();
    auto_eoi = 1;
    irq_in = 8'h08; step();
    do_ack("R7 vector, isr untouched", 3'd3, 8'h00);
    irq_in = 8'h28; step();
    chk("R7 no nesting", {7'd0, int_out}, 8'd1);
    do_ack("R7 second", 3'd5, 8'h00);
    auto_eoi = 0; irq_in = 0; step();
  endtask

  task automatic t_sfnm();
    irq_in = 8'h04; step();
    do_ack("R8 first cascade", 3'd2, 8'h04);
    irq_in = 0; step(); irq_in = 8'h04; step();
    chk("R8 normal mode blocks", {7'd0, int_out}, 8'd0);
    sfnm = 1; #1;
    chk("R8 cascade recognised", {7'd0, int_out}, 8'd1);
    step();
    do_ack("R8 second cascade", 3'd2, 8'h04);
    irq_in = 8'h14; step();
    chk("R8 lower still held", {7'd0, int_out}, 8'd0);
    do_eoi("R8 eoi", 8'h00);
    chk("R8 released", {7'd0, int_out}, 8'd1);
    do_ack("R8 level 4", 3'd4, 8'h10);
    do_eoi("R8 clean", 8'h00);
    sfnm = 0; irq_in = 0; step();
  endtask

  task automatic t_smm();
    smm = 1;
    irq_in = 8'h02; step();
    do_ack("R9 level 1", 3'd1, 8'h02);
    irq_in = 8'h42; step();
    chk("R9 lower not held", {7'd0, int_out}, 8'd1);
    do_ack("R9 level 6", 3'd6, 8'h42);
    set_mask(8'h80);
    irq_in = 8'hC2; step();
    chk("R9 mask still holds", {7'd0, int_out}, 8'd0);
    do_eoi("R5 smm eoi order", 8'h40);
    do_eoi("R5 smm eoi last", 8'h00);
    set_mask(8'h00);
    smm = 0; irq_in = 0; step();
  endtask

  initial begin
    fork
      begin
        step(); step(); rst_n = 1; step();
        t_reset();
        t_priority();
        t_mask();
        t_spurious();
        t_aeoi();
        t_sfnm();
        t_smm();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule